// File: doc/BRIEF.md
# APB3 Requester with Fault Escalation

This block is the requesting side of an APB3 bus. A local client hands it one read or write command at a time over a valid/ready handshake. The block runs each command on the bus as a setup cycle followed by one or more access cycles. It waits for the subordinate's ready signal, and it samples the subordinate's error bit only in the completing cycle. One cycle after completion it returns a single-cycle response pulse to the client, with a pass/fail flag and, for a clean read, the read data.

A failed access still finishes on the bus like any other. It is never aborted or rolled back. The block does not treat it as a success, though. The client receives all-zero data instead of whatever the subordinate drove. A bus-fault pulse marks that specific response. A sticky record keeps the address and direction of the faulting access until the client clears it, and a saturating counter tallies failed accesses. The error bit is one pass/fail verdict: the block infers no cause and reports none. A new command can be accepted in the completion cycle, so transfers can run back to back with no idle cycle between them.

Top module: `apbm_err_manager`

## Requirements
- R1: While reset is asserted and in the first cycle after it, psel, penable, rsp_valid, rsp_err, bus_fault and fault_valid are low, fault_count is zero and cmd_ready is high.
- R2: Every transfer begins with exactly one cycle of psel high and penable low, followed by cycles with both psel and penable high.
- R3: When pready is high in the first access cycle, psel stays high for exactly two cycles. Each access cycle with pready low adds one cycle. paddr, pwrite and pwdata do not change from the setup cycle until completion.
- R4: A transfer completes only in a cycle where psel, penable and pready are all high. The values of pready and pslverr in any other cycle have no effect on any output.
- R5: rsp_valid is high for exactly one cycle, the cycle after each completion. rsp_err equals the pslverr value sampled at that completion.
- R6: For a clean read, rsp_rdata equals the prdata sampled at completion. For a failed access or any write, rsp_rdata is all zeros.
- R7: An asserted pslverr does not lengthen or abort the transfer. In the cycle after completion the bus is idle (psel low), or in the setup cycle of the next command, exactly as after a clean access.
- R8: bus_fault is high in exactly the cycles where rsp_valid and rsp_err are both high.
- R9: On a failed access while no fault is recorded, fault_valid goes high in the response cycle with fault_addr set to that access's address and fault_write set to its direction (1 for a write). Later failures do not change the record until fault_clear is sampled high. The clear takes effect on the next clock edge. A failure that completes on that same edge is recorded.
- R10: fault_count increments by one for each failed access and saturates at 2^CNT_W-1. fault_clear sets it to zero, or to one if a failed access completes on the same edge.
- R11: cmd_ready is high when the bus is idle and in a completion cycle, and low in all other cycles. A command accepted in a completion cycle puts the bus in its setup cycle on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Client offers a command |
| cmd_ready | output | 1 | Block accepts the offered command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access failed |
| rsp_rdata | output | DATA_W | Read data, zero unless a clean read |
| bus_fault | output | 1 | Fault escalation pulse for this response |
| fault_clear | input | 1 | Clears the fault record and counter |
| fault_valid | output | 1 | A fault is recorded |
| fault_addr | output | ADDR_W | Address of the recorded fault |
| fault_write | output | 1 | Direction of the recorded fault |
| fault_count | output | CNT_W | Saturating count of failed accesses |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB subordinate ready |
| pslverr | input | 1 | APB subordinate error verdict |

## Verification
A wrong phase state appears at the bus pins in the next cycle: a missing setup cycle, an access that never ends, or a select that drops early. The same fault also shows up at cmd_ready, which either accepts a command in the middle of a transfer or never accepts one. A wrong sampling point for the verdict appears one cycle later, at the response. rsp_err or bus_fault fires after a garbage error pulse in a wait or setup cycle, or read data leaks through on a failure. A broken fault record or counter is caught on the response edge of the failing access, when fault_addr, fault_write or fault_count differ from a model that keeps only the first fault and saturates the count.

// File: rtl/apbm_pkg.sv
package apbm_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2
   } apbm_phase_e;

endpackage

// File: rtl/apbm_seq.sv
module apbm_seq
   import apbm_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              pready,
   output logic              psel,
   output logic              penable,
   output logic              pwrite,
   output logic [ADDR_W-1:0] paddr,
   output logic [DATA_W-1:0] pwdata,
   output logic              xfer_done
);

   apbm_phase_e phase_q, phase_d;
   logic        take;

   always_comb begin
      xfer_done = (phase_q == PH_ACCESS) && pready;
      cmd_ready = (phase_q == PH_IDLE) || xfer_done;
      take      = cmd_valid && cmd_ready;
   end

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (take) phase_d = PH_SETUP;
         PH_SETUP:  phase_d = PH_ACCESS;
         PH_ACCESS: if (pready) phase_d = take ? PH_SETUP : PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pwrite  <= 1'b0;
         paddr   <= '0;
         pwdata  <= '0;
      end else begin
         phase_q <= phase_d;
         if (take) begin
            pwrite <= cmd_write;
            paddr  <= cmd_addr;
            pwdata <= cmd_wdata;
         end
      end
   end

   assign psel    = (phase_q != PH_IDLE);
   assign penable = (phase_q == PH_ACCESS);

   AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      penable |-> psel); // R2
   AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable) |=> (psel && penable)); // R2
   AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !(penable && pready)) |=> ($stable(paddr) && $stable(pwrite) && $stable(pwdata))); // R3
   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !cmd_valid) |=> !psel); // R7
   AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && cmd_valid) |=> (psel && !penable)); // R11

endmodule

// File: rtl/apbm_resp.sv
module apbm_resp #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_done,
   input  logic              xfer_write,
   input  logic              pslverr,
   input  logic [DATA_W-1:0] prdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic data_ok;

   assign data_ok = !pslverr && !xfer_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= xfer_done;
         rsp_err   <= xfer_done && pslverr;
         rsp_rdata <= (xfer_done && data_ok) ? prdata : '0;
      end
   end

   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !xfer_done) |=> !rsp_valid); // R5
   AST_NO_DATA_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R6

endmodule

// File: rtl/apbm_fault_log.sv
module apbm_fault_log #(
   parameter int ADDR_W     = 12,
   parameter int CNT_W      = 4,
   parameter bit KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_ev,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              ev_write,
   input  logic              clear,
   output logic              fault_valid,
   output logic [ADDR_W-1:0] fault_addr,
   output logic              fault_write,
   output logic [CNT_W-1:0]  fault_count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic load;

   generate
      if (KEEP_FIRST) begin : g_keep_first
         assign load = fault_ev && (clear || !fault_valid);
      end else begin : g_keep_last
         assign load = fault_ev;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_valid <= 1'b0;
         fault_addr  <= '0;
         fault_write <= 1'b0;
         fault_count <= '0;
      end else begin
         if (fault_ev)   fault_valid <= 1'b1;
         else if (clear) fault_valid <= 1'b0;
         if (load) begin
            fault_addr  <= ev_addr;
            fault_write <= ev_write;
         end
         if (clear)
            fault_count <= fault_ev ? CNT_W'(1) : '0;
         else if (fault_ev && fault_count != CNT_MAX)
            fault_count <= fault_count + 1'b1;
      end
   end

   AST_COUNT_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_count == CNT_MAX && !clear) |=> (fault_count == CNT_MAX)); // R10
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !fault_ev) |=> $stable(fault_count)); // R10

   generate
      if (KEEP_FIRST) begin : g_first_chk
         AST_FIRST_FAULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_valid && !clear) |=> (fault_valid && $stable(fault_addr) && $stable(fault_write))); // R9
      end
   endgenerate

endmodule

// File: rtl/apbm_err_manager.sv
module apbm_err_manager #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 4,
   parameter bit KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bus_fault,
   input  logic              fault_clear,
   output logic              fault_valid,
   output logic [ADDR_W-1:0] fault_addr,
   output logic              fault_write,
   output logic [CNT_W-1:0]  fault_count,
   output logic              psel,
   output logic              penable,
   output logic              pwrite,
   output logic [ADDR_W-1:0] paddr,
   output logic [DATA_W-1:0] pwdata,
   input  logic [DATA_W-1:0] prdata,
   input  logic              pready,
   input  logic              pslverr
);

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
         $error("apbm_err_manager: ADDR_W must lie in 2..32");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
         $error("apbm_err_manager: DATA_W must be a whole number of bytes");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("apbm_err_manager: CNT_W must lie in 1..16");
      end
   endgenerate

   logic xfer_done;
   logic fault_ev;

   apbm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_write (cmd_write),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .pready    (pready),
      .psel      (psel),
      .penable   (penable),
      .pwrite    (pwrite),
      .paddr     (paddr),
      .pwdata    (pwdata),
      .xfer_done (xfer_done)
   );

   apbm_resp #(.DATA_W(DATA_W)) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_done  (xfer_done),
      .xfer_write (pwrite),
      .pslverr    (pslverr),
      .prdata     (prdata),
      .rsp_valid  (rsp_valid),
      .rsp_err    (rsp_err),
      .rsp_rdata  (rsp_rdata)
   );

   assign fault_ev = xfer_done && pslverr;

   apbm_fault_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .KEEP_FIRST(KEEP_FIRST)) u_flog (
      .clk         (clk),
      .rst_n       (rst_n),
      .fault_ev    (fault_ev),
      .ev_addr     (paddr),
      .ev_write    (pwrite),
      .clear       (fault_clear),
      .fault_valid (fault_valid),
      .fault_addr  (fault_addr),
      .fault_write (fault_write),
      .fault_count (fault_count)
   );

   assign bus_fault = rsp_valid && rsp_err;

   AST_RSP_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> rsp_valid); // R5
   AST_FAULT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && pslverr) |=> (fault_valid && bus_fault)); // R9
   AST_QUIET_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(psel && penable && pready) |=> !rsp_valid); // R4

endmodule

// File: tb/apbm_err_manager_tb.sv
module apbm_err_manager_tb;

   localparam int AW = 12;
   localparam int DW = 32;
   localparam int CW = 4;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic          cmd_write = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          rsp_valid, rsp_err, bus_fault;
   logic [DW-1:0] rsp_rdata;
   logic          fault_clear = 1'b0;
   logic          fault_valid, fault_write;
   logic [AW-1:0] fault_addr;
   logic [CW-1:0] fault_count;
   logic          psel, penable, pwrite;
   logic [AW-1:0] paddr;
   logic [DW-1:0] pwdata;
   logic [DW-1:0] prdata = '0;
   logic          pready = 1'b0;
   logic          pslverr = 1'b0;

   always #2 clk = ~clk;

   apbm_err_manager #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_fault(bus_fault), .fault_clear(fault_clear),
      .fault_valid(fault_valid), .fault_addr(fault_addr),
      .fault_write(fault_write), .fault_count(fault_count),
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
      return (DW'(a) * 32'h0001_9E37) ^ 32'h5A5A_1234;
   endfunction

   typedef struct {
      logic [AW-1:0] addr;
      logic          wr;
      logic [DW-1:0] wdata;
   } cmd_t;

   typedef struct {
      logic [AW-1:0] addr;
      logic          wr;
      logic          err;
      int            waits;
   } done_t;

   cmd_t  cmdq[$];
   done_t doneq[$];

   // subordinate model controls
   int force_waits = 0;   // -1: random 0..3
   int err_pct     = 0;
   int sub_left    = 0;
   int sub_waits   = 0;
   bit sub_err     = 1'b0;

   always @(negedge clk) begin
      if (psel && !penable) begin
         sub_waits = (force_waits < 0) ? int'($urandom % 4) : force_waits;
         sub_left  = sub_waits;
         sub_err   = (int'($urandom % 100) < err_pct);
         pready   <= 1'($urandom);   // ignored outside access (R4)
         pslverr  <= 1'($urandom);
         prdata   <= $urandom;
      end else if (psel && penable) begin
         if (sub_left == 0) begin
            pready  <= 1'b1;
            pslverr <= sub_err;
            prdata  <= pattern(paddr);
            doneq.push_back('{addr: paddr, wr: pwrite, err: sub_err, waits: sub_waits});
         end else begin
            sub_left = sub_left - 1;
            pready  <= 1'b0;
            pslverr <= 1'($urandom);
            prdata  <= $urandom;
         end
      end else begin
         pready  <= 1'($urandom);
         pslverr <= 1'($urandom);
         prdata  <= $urandom;
      end
   end

   // monitor and reference model
   bit            done_prev = 1'b0;
   bit            acc_prev  = 1'b0;
   bit            clr_prev  = 1'b0;
   int            cyc       = 0;
   logic [AW-1:0] lat_addr;
   logic          lat_wr;
   logic [DW-1:0] lat_wd;
   bit            m_fv   = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic          m_wr   = 1'b0;
   logic [CW-1:0] m_cnt  = '0;
   bit            mon_on = 1'b0;

   always @(negedge clk) begin
      #2;
      if (mon_on) begin
         // R1 model clear first, then event of the same edge (R9, R10)
         if (clr_prev) begin
            m_fv  = 1'b0;
            m_cnt = '0;
         end
         chk(rsp_valid == done_prev, "R5", "rsp_valid one cycle after completion (R4)", 64'(rsp_valid), 64'(done_prev));
         if (done_prev) begin
            if (acc_prev)
               chk(psel && !penable, "R11", "setup right after completion", {penable, psel}, 64'b01);
            else
               chk(!psel, "R7", "bus idle after completion", 64'(psel), 64'd0);
         end
         if (rsp_valid && doneq.size() > 0) begin
            done_t d;
            logic [DW-1:0] er;
            d  = doneq.pop_front();
            er = (d.err || d.wr) ? '0 : pattern(d.addr);
            chk(rsp_err == d.err, "R5", "rsp_err verdict", 64'(rsp_err), 64'(d.err));
            chk(rsp_rdata == er, "R6", "rsp_rdata gating", 64'(rsp_rdata), 64'(er));
            if (d.err) begin
               if (!m_fv) begin
                  m_fv   = 1'b1;
                  m_addr = d.addr;
                  m_wr   = d.wr;
               end
               if (m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
            end
         end else if (rsp_valid) begin
            chk(1'b0, "R5", "response without completion", 64'd1, 64'd0);
         end
         chk(bus_fault == (rsp_valid && rsp_err), "R8", "bus_fault pulse", 64'(bus_fault), 64'(rsp_valid && rsp_err));
         chk(fault_valid == m_fv, "R9", "fault_valid", 64'(fault_valid), 64'(m_fv));
         if (m_fv) begin
            chk(fault_addr == m_addr, "R9", "fault_addr", 64'(fault_addr), 64'(m_addr));
            chk(fault_write == m_wr, "R9", "fault_write", 64'(fault_write), 64'(m_wr));
         end
         chk(fault_count == m_cnt, "R10", "fault_count", 64'(fault_count), 64'(m_cnt));
         chk(cmd_ready == (!psel || (penable && pready)), "R11", "cmd_ready", 64'(cmd_ready), 64'(!psel || (penable && pready)));
         chk(!penable || psel, "R2", "penable without psel", 64'(penable), 64'(psel));

         if (psel) cyc++;
         if (psel && !penable) begin
            chk(cyc == 1, "R2", "single setup cycle", 64'(cyc), 64'd1);
            if (cmdq.size() > 0) begin
               cmd_t c;
               c = cmdq[0];
               chk(paddr == c.addr && pwrite == c.wr && (!c.wr || pwdata == c.wdata),
                   "R2", "bus carries command", 64'(paddr), 64'(c.addr));
            end else begin
               chk(1'b0, "R2", "setup without command", 64'd1, 64'd0);
            end
            lat_addr = paddr; lat_wr = pwrite; lat_wd = pwdata;
         end else if (psel) begin
            chk(paddr == lat_addr && pwrite == lat_wr && pwdata == lat_wd,
                "R3", "bus stable through access", 64'(paddr), 64'(lat_addr));
         end
         done_prev = psel && penable && pready;
         if (done_prev) begin
            chk(cyc == 2 + sub_waits, "R3", "transfer length", 64'(cyc), 64'(2 + sub_waits));
            cyc = 0;
            if (cmdq.size() > 0) void'(cmdq.pop_front());
         end
         acc_prev = cmd_valid && cmd_ready;
         clr_prev = fault_clear;
      end
   end

   task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd);
      cmd_valid = 1'b1;
      cmd_write = wr;
      cmd_addr  = a;
      cmd_wdata = wd;
      #1;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      cmdq.push_back('{addr: a, wr: wr, wdata: wd});
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      cmd_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      cmd_valid = 1'b0;
      while (psel || cmdq.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse_clear();
      fault_clear = 1'b1;
      @(negedge clk);
      fault_clear = 1'b0;
   endtask

   bit clr_rand = 1'b0;
   always @(negedge clk) begin
      if (clr_rand) fault_clear <= (($urandom % 40) == 0);
   end

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      #2;
      // R1 during reset
      chk(!psel && !penable, "R1", "bus idle in reset", {penable, psel}, 64'd0);
      chk(!rsp_valid && !bus_fault && !fault_valid, "R1", "no response or fault in reset",
          {fault_valid, bus_fault, rsp_valid}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!psel && !penable && cmd_ready, "R1", "idle and ready after reset",
          {cmd_ready, penable, psel}, 64'b100);
      chk(fault_count == '0 && !rsp_err, "R1", "count zero after reset", 64'(fault_count), 64'd0);
      @(negedge clk);
      mon_on = 1'b1;

      // directed: zero-wait clean read and write (R3, R6)
      force_waits = 0; err_pct = 0;
      send(1'b0, 12'h010, '0);
      idle(4);
      send(1'b1, 12'h024, 32'hDEAD_BEEF);
      idle(4);
      // directed: zero-wait failed read, then failed write (R6, R8, R9)
      err_pct = 100;
      send(1'b0, 12'h7F0, '0);
      idle(4);
      send(1'b1, 12'h044, 32'h1111_2222);
      idle(4);
      // directed: wait states with errors (R3, R4, R7)
      force_waits = 3;
      send(1'b0, 12'h100, '0);
      idle(6);
      err_pct = 0;
      send(1'b0, 12'h104, '0);
      idle(6);
      // directed: back-to-back mixed (R11)
      force_waits = 0; err_pct = 50;
      for (int i = 0; i < 8; i++) send(1'(i), AW'(12'h200 + i * 4), $urandom);
      drain();
      // directed: clear (R9, R10)
      pulse_clear();
      idle(2);
      // saturation: 20 failures without clear (R10)
      err_pct = 100; force_waits = -1;
      for (int i = 0; i < 20; i++) send(1'($urandom), AW'($urandom), $urandom);
      drain();
      chk(fault_count == CMAX, "R10", "counter saturated", 64'(fault_count), 64'(CMAX));
      pulse_clear();
      idle(2);
      // random phase with random clears (R4, R9, R10, R11)
      err_pct = 30; clr_rand = 1'b1;
      for (int i = 0; i < 400; i++) begin
         send(1'($urandom), AW'($urandom), $urandom);
         if (($urandom % 4) == 0) idle(int'($urandom % 3));
      end
      drain();
      clr_rand = 1'b0;
      fault_clear = 1'b0;
      idle(3);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule